// File: doc/BRIEF.md
# Dual-Line Serial ADC Reader

This block sits on the host side of a two-channel sampling converter. The converter has one chip select and one serial clock that both channels share, and it returns its two results on two separate data lines at the same time. When the block sees a start request, it lowers chip select and then generates exactly sixteen serial clock periods. During those periods it shifts both data lines into their own shift registers in lockstep. It then raises chip select and publishes two 12-bit results together with a one-cycle valid strobe.

The speed of the serial clock is set by a half-period count, given in system clock cycles. The block clamps this count between a lower and an upper limit, so the serial clock stays inside the range the converter allows. After each frame the block keeps chip select high for a minimum quiet interval before the next frame can begin. A start request that arrives while a frame or a quiet gap is in progress is remembered. That request is served as soon as the gap has elapsed.

Top module: `dual_adc_reader`

## Requirements
- R1: During reset and directly after it, `cs_n` and `sclk` are 1, while `busy`, `res_valid`, `res_a` and `res_b` are all 0.
- R2: Each low period of `cs_n` contains exactly 16 falling edges and 16 rising edges of `sclk`, always in falling-then-rising order.
- R3: Each low phase and each high phase of `sclk` inside a frame lasts H system cycles, so the duty cycle is 50/50. H is `half_div` clamped to the range 3 to 250, and it is captured when the frame starts.
- R4: After `cs_n` falls, at least 1 system cycle passes before the first falling edge of `sclk`.
- R5: Each data line is sampled at each rising edge of `sclk`, most-significant bit first. The first 4 of the 16 bits are discarded, and bits 11..0 of the 16-bit word sent on a line become that line's result.
- R6: `res_valid` is a one-cycle pulse. It is raised in the same cycle that `cs_n` returns high, and `res_a` and `res_b` change only in that cycle, together.
- R7: Between a rising edge of `cs_n` and the next falling edge of `cs_n`, `cs_n` stays high for at least 6 system cycles.
- R8: A start request raised while `busy` is 1 is held, and it opens exactly one further frame after the quiet gap. `busy` is 1 while a request is pending and for the whole time `cs_n` is low.
- R9: While `cs_n` is high, activity on `sdat_a` and `sdat_b` has no effect on the results, on `res_valid`, or on the next frame.
- R10: `sclk` is high whenever `cs_n` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Request for one conversion frame |
| half_div | input | 8 | Serial clock half period in system cycles, before clamping |
| cs_n | output | 1 | Chip select to the converter, active low |
| sclk | output | 1 | Serial clock to the converter, idles high |
| sdat_a | input | 1 | Serial data from channel A |
| sdat_b | input | 1 | Serial data from channel B |
| res_a | output | 12 | Last result from channel A |
| res_b | output | 12 | Last result from channel B |
| res_valid | output | 1 | One-cycle strobe when both results update |
| busy | output | 1 | Request pending, frame active or quiet gap running |

## Verification
The bench walks a single one through every bit position of the 16-bit frame on one line and its complement on the other. A reader that keeps the wrong 12 bits, samples on the wrong serial clock edge or swaps the two lines would then show a shifted or leaked bit. It sweeps `half_div` across 0, 2, the lower limit, ordinary values, the upper limit and values above it. A missing or off-by-one clamp would show up as a wrong phase length. A frame with one edge too many or too few would show up in the per-frame edge count. The bench also raises requests in the middle of a frame and drives noise on the data lines between frames. A design that dropped or duplicated a held request, cut the quiet gap short, or shifted while deselected would produce an extra frame, a missing frame, a short gap, or corrupted results.

// File: rtl/dar_pkg.sv
// Package: shared types for the dual-line serial ADC reader.
// Assumes nothing beyond standard SystemVerilog.
package dar_pkg;

    // Frame sequencer states.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_LOW,
        ST_HIGH,
        ST_QUIET
    } dar_state_e;

endpackage

// File: rtl/dar_div_clamp.sv
// Module: dar_div_clamp
// Limits the requested serial clock half period to [MIN_HALF, MAX_HALF].
// Assumes 1 <= MIN_HALF <= MAX_HALF < 2**DIV_W.
module dar_div_clamp #(
    parameter int DIV_W    = 8,
    parameter int MIN_HALF = 3,
    parameter int MAX_HALF = 250
) (
    input  logic [DIV_W-1:0] div_in,
    output logic [DIV_W-1:0] half_out
);
    localparam logic [DIV_W-1:0] LO = DIV_W'(MIN_HALF);
    localparam logic [DIV_W-1:0] HI = DIV_W'(MAX_HALF);

    // Pick the nearest legal half period.
    always_comb begin
        if (div_in < LO)      half_out = LO;
        else if (div_in > HI) half_out = HI;
        else                  half_out = div_in;
    end
endmodule

// File: rtl/dar_seq.sv
// Module: dar_seq
// Frame sequencer: holds start requests, drives chip select and the serial
// clock, and flags the sample and completion points of each frame.
// Assumes half >= 1, SETUP_CYC >= 1 and QUIET_CYC >= 1.
module dar_seq
    import dar_pkg::*;
#(
    parameter int DIV_W      = 8,
    parameter int FRAME_BITS = 16,
    parameter int SETUP_CYC  = 1,
    parameter int QUIET_CYC  = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [DIV_W-1:0] half,
    output logic             cs_n,
    output logic             sclk,
    output logic             busy,
    output logic             sample,
    output logic             done
);
    localparam int QW    = $clog2(QUIET_CYC + 1);
    localparam int SW    = $clog2(SETUP_CYC + 1);
    localparam int MW    = (QW > SW) ? QW : SW;
    localparam int CNT_W = (DIV_W > MW) ? DIV_W : MW;
    localparam int BIT_W = $clog2(FRAME_BITS + 1);
    localparam logic [CNT_W-1:0] SETUP_LAST = CNT_W'(SETUP_CYC - 1);
    localparam logic [CNT_W-1:0] QUIET_LAST = CNT_W'(QUIET_CYC - 1);
    localparam logic [BIT_W-1:0] LAST_BIT   = BIT_W'(FRAME_BITS);

    dar_state_e       state;
    logic [CNT_W-1:0] cnt;
    logic [BIT_W-1:0] bits;
    logic [DIV_W-1:0] half_q;
    logic [CNT_W-1:0] half_last;
    logic             pend;
    logic             take;
    logic             phase_end;

    assign half_last = CNT_W'(half_q) - CNT_W'(1);
    assign phase_end = (cnt == half_last);
    assign take      = (state == ST_IDLE) && pend;
    assign sample    = (state == ST_LOW) && phase_end;
    assign done      = (state == ST_HIGH) && phase_end && (bits == LAST_BIT);
    assign busy      = (state != ST_IDLE) || pend;

    // Remember one start request until a frame opens.
    always_ff @(posedge clk) begin
        if (!rst_n) pend <= 1'b0;
        else        pend <= start || (pend && !take);
    end

    // Step through setup, sixteen clock periods and the quiet gap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            cnt    <= '0;
            bits   <= '0;
            half_q <= '0;
            cs_n   <= 1'b1;
            sclk   <= 1'b1;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (pend) begin
                        state  <= ST_SETUP;
                        cs_n   <= 1'b0;
                        cnt    <= '0;
                        bits   <= '0;
                        half_q <= half;
                    end
                end
                ST_SETUP: begin
                    if (cnt == SETUP_LAST) begin
                        state <= ST_LOW;
                        sclk  <= 1'b0;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                ST_LOW: begin
                    if (phase_end) begin
                        state <= ST_HIGH;
                        sclk  <= 1'b1;
                        cnt   <= '0;
                        bits  <= bits + BIT_W'(1);
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                ST_HIGH: begin
                    if (phase_end) begin
                        cnt <= '0;
                        if (bits == LAST_BIT) begin
                            state <= ST_QUIET;
                            cs_n  <= 1'b1;
                        end else begin
                            state <= ST_LOW;
                            sclk  <= 1'b0;
                        end
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                ST_QUIET: begin
                    if (cnt == QUIET_LAST) begin
                        state <= ST_IDLE;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/dar_capture.sv
// Module: dar_capture
// One shift register per data line, all shifted on the same sample strobe;
// the low RES_W bits are published together when the frame completes.
// Assumes sample only occurs while the converter is selected.
module dar_capture #(
    parameter int LANES = 2,
    parameter int RES_W = 12
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        sample,
    input  logic                        done,
    input  logic [LANES-1:0]            sd,
    output logic [LANES-1:0][RES_W-1:0] res,
    output logic                        valid
);
    genvar g;
    generate
        for (g = 0; g < LANES; g++) begin : g_lane
            logic [RES_W-1:0] shreg;

            // Shift the line in MSB first; older bits fall off the top.
            always_ff @(posedge clk) begin
                if (!rst_n)      shreg <= '0;
                else if (sample) shreg <= {shreg[RES_W-2:0], sd[g]};
            end

            // Publish the lane result at frame completion.
            always_ff @(posedge clk) begin
                if (!rst_n)    res[g] <= '0;
                else if (done) res[g] <= shreg;
            end
        end
    endgenerate

    // Strobe once when all lanes update.
    always_ff @(posedge clk) begin
        if (!rst_n) valid <= 1'b0;
        else        valid <= done;
    end
endmodule

// File: rtl/dual_adc_reader.sv
// Module: dual_adc_reader (top)
// Reads two 12-bit results at once from a converter that shares one chip
// select and one serial clock across two data lines.
// Assumes the data lines change after falling serial clock edges and are
// stable by the next rising edge.
module dual_adc_reader #(
    parameter int DIV_W      = 8,
    parameter int MIN_HALF   = 3,
    parameter int MAX_HALF   = 250,
    parameter int FRAME_BITS = 16,
    parameter int RES_W      = 12,
    parameter int SETUP_CYC  = 1,
    parameter int QUIET_CYC  = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [DIV_W-1:0] half_div,
    output logic             cs_n,
    output logic             sclk,
    input  logic             sdat_a,
    input  logic             sdat_b,
    output logic [RES_W-1:0] res_a,
    output logic [RES_W-1:0] res_b,
    output logic             res_valid,
    output logic             busy
);
    logic [DIV_W-1:0]    half;
    logic                sample;
    logic                done;
    logic [1:0][RES_W-1:0] res;

    dar_div_clamp #(
        .DIV_W(DIV_W), .MIN_HALF(MIN_HALF), .MAX_HALF(MAX_HALF)
    ) u_clamp (
        .div_in(half_div), .half_out(half)
    );

    dar_seq #(
        .DIV_W(DIV_W), .FRAME_BITS(FRAME_BITS),
        .SETUP_CYC(SETUP_CYC), .QUIET_CYC(QUIET_CYC)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .half(half),
        .cs_n(cs_n), .sclk(sclk), .busy(busy),
        .sample(sample), .done(done)
    );

    dar_capture #(
        .LANES(2), .RES_W(RES_W)
    ) u_cap (
        .clk(clk), .rst_n(rst_n), .sample(sample), .done(done),
        .sd({sdat_b, sdat_a}), .res(res), .valid(res_valid)
    );

    assign res_a = res[0];
    assign res_b = res[1];
endmodule

// File: rtl/dar_checker.sv
// Module: dar_checker
// Protocol checks on the reader's ports, bound into dual_adc_reader.
// Assumes reset is held low from time zero.
module dar_checker #(
    parameter int FRAME_BITS = 16,
    parameter int RES_W      = 12,
    parameter int QUIET_CYC  = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cs_n,
    input logic             sclk,
    input logic             busy,
    input logic             res_valid,
    input logic [RES_W-1:0] res_a,
    input logic [RES_W-1:0] res_b
);
    localparam int FW = $clog2(FRAME_BITS + 1) + 1;
    localparam int HW = $clog2(QUIET_CYC + 2) + 1;
    localparam logic [FW-1:0] FALLS_EXP = FW'(FRAME_BITS);
    localparam logic [HW-1:0] HI_MIN    = HW'(QUIET_CYC + 1);

    logic          sclk_d;
    logic [FW-1:0] fall_cnt;
    logic [HW-1:0] hi_cnt;

    // Count serial clock falls inside the current select period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_d   <= 1'b1;
            fall_cnt <= '0;
        end else begin
            sclk_d <= sclk;
            if (cs_n)                 fall_cnt <= '0;
            else if (sclk_d && !sclk) fall_cnt <= fall_cnt + FW'(1);
        end
    end

    // Count deselected cycles, saturating at the required minimum.
    always_ff @(posedge clk) begin
        if (!rst_n)               hi_cnt <= HI_MIN;
        else if (!cs_n)           hi_cnt <= '0;
        else if (hi_cnt < HI_MIN) hi_cnt <= hi_cnt + HW'(1);
    end

    p_edges_per_frame_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |-> fall_cnt == FALLS_EXP);

    p_valid_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);

    p_valid_at_deselect_r6: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $rose(cs_n));

    p_results_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> ($stable(res_a) && $stable(res_b)));

    p_quiet_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> hi_cnt >= HI_MIN);

    p_busy_in_frame_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n |-> busy);

    p_sclk_idle_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> sclk);
endmodule

bind dual_adc_reader dar_checker #(
    .FRAME_BITS(FRAME_BITS), .RES_W(RES_W), .QUIET_CYC(QUIET_CYC)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .busy(busy),
    .res_valid(res_valid), .res_a(res_a), .res_b(res_b)
);

// File: tb/sim_dual_adc_reader.sv
// Bench: sweeps clock settings and bit patterns against a two-line converter
// model; expected values come from the requirements only.
module sim_dual_adc_reader;
    localparam int CLK_PERIOD = 10;
    localparam int MIN_H      = 3;
    localparam int MAX_H      = 250;
    localparam int SETUP_C    = 1;
    localparam int QUIET_C    = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  half_div = 8'd3;
    logic        cs_n, sclk, sdat_a, sdat_b;
    logic [11:0] res_a, res_b;
    logic        res_valid, busy;

    logic [15:0] word_a = '0, word_b = '0;
    logic        drv_a = 1'b0, drv_b = 1'b0;
    logic        noise_a = 1'b0, noise_b = 1'b0;
    int          bit_idx = 15;

    int errors = 0, checks = 0, cycles = 0;
    int exp_half = MIN_H;
    int frames = 0, falls = 0, edges = 0, run = 0, hi_run = 100;
    logic prev_cs = 1'b1, prev_sclk = 1'b1;

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_adc_reader u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .half_div(half_div),
        .cs_n(cs_n), .sclk(sclk), .sdat_a(sdat_a), .sdat_b(sdat_b),
        .res_a(res_a), .res_b(res_b), .res_valid(res_valid), .busy(busy)
    );

    // Lines float to noise while deselected.
    assign sdat_a = cs_n ? noise_a : drv_a;
    assign sdat_b = cs_n ? noise_b : drv_b;

    // Converter model: next bit after each falling serial clock edge.
    always @(negedge cs_n) bit_idx = 15;
    always @(negedge sclk) begin
        if (!cs_n) begin
            drv_a <= word_a[bit_idx];
            drv_b <= word_b[bit_idx];
            bit_idx = bit_idx - 1;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int clamp_h(input int h);
        if (h < MIN_H) return MIN_H;
        if (h > MAX_H) return MAX_H;
        return h;
    endfunction

    // Timing monitor sampled between clock edges.
    always @(negedge clk) begin
        if (rst_n) begin
            if (cs_n) begin
                if (!prev_cs) begin
                    chk(falls == 16, "R2 sclk falls per frame", falls, 16);
                    chk(sclk == 1'b1, "R10 sclk high at deselect", sclk, 1);
                    hi_run = 1;
                end else begin
                    hi_run++;
                end
            end else if (prev_cs) begin
                frames++;
                chk(hi_run >= QUIET_C + 1, "R7 quiet gap", hi_run, QUIET_C + 1);
                run = 1; falls = 0; edges = 0;
            end else if (sclk != prev_sclk) begin
                if (edges == 0) begin
                    chk(run >= SETUP_C, "R4 cs to first sclk", run, SETUP_C);
                    chk(sclk == 1'b0, "R2 first edge falls", sclk, 0);
                end else begin
                    chk(run == exp_half, "R3 phase length", run, exp_half);
                end
                edges++;
                if (!sclk) falls++;
                run = 1;
            end else begin
                run++;
            end
            prev_cs = cs_n;
            prev_sclk = sclk;
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++; checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic pulse_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    task automatic wait_valid();
        int n = 0;
        while (!res_valid && n < 20000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic check_result(input logic [15:0] wa, input logic [15:0] wb);
        chk(res_valid == 1'b1, "R6 valid seen", res_valid, 1);
        chk(res_a == wa[11:0], "R5 res_a", res_a, wa[11:0]);
        chk(res_b == wb[11:0], "R5 res_b", res_b, wb[11:0]);
        chk(cs_n == 1'b1, "R6 cs high with valid", cs_n, 1);
        @(negedge clk);
        chk(res_valid == 1'b0, "R6 valid one cycle", res_valid, 0);
    endtask

    task automatic run_frame(input logic [15:0] wa, input logic [15:0] wb, input int hd);
        word_a = wa; word_b = wb;
        half_div = 8'(hd);
        exp_half = clamp_h(hd);
        pulse_start();
        wait_valid();
        check_result(wa, wb);
        while (busy) @(negedge clk);
    endtask

    initial begin
        int hvals[8] = '{0, 2, 3, 4, 7, 249, 250, 255};
        int f0;
        logic [11:0] keep_a, keep_b;
        bit saw_valid;

        // R1: reset state
        repeat (3) @(negedge clk);
        chk(cs_n == 1'b1 && sclk == 1'b1, "R1 cs/sclk in reset", {cs_n, sclk}, 3);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cs_n == 1'b1, "R1 cs_n", cs_n, 1);
        chk(sclk == 1'b1, "R1 sclk", sclk, 1);
        chk(busy == 1'b0, "R1 busy", busy, 0);
        chk(res_valid == 1'b0, "R1 valid", res_valid, 0);
        chk(res_a == 0 && res_b == 0, "R1 results", {res_a, res_b}, 0);

        // R5 / R2: walking one over all 16 positions, complement on B
        for (int i = 0; i < 16; i++) begin
            run_frame(16'(1 << i), ~16'(1 << i), 3);
        end

        // R3: divider sweep including both clamp limits
        for (int k = 0; k < 8; k++) begin
            logic [15:0] pa, pb;
            pa = 16'hA5C3 ^ 16'(k * 16'h1357);
            pb = {pa[7:0], pa[15:8]} ^ 16'h0FF0;
            run_frame(pa, pb, hvals[k]);
        end

        // R8: requests during a frame collapse into one held frame
        f0 = frames;
        word_a = 16'h1234; word_b = 16'hFEDC;
        half_div = 8'd4; exp_half = 4;
        pulse_start();
        repeat (30) @(negedge clk);
        chk(busy == 1'b1, "R8 busy in frame", busy, 1);
        pulse_start();
        repeat (5) @(negedge clk);
        pulse_start();
        wait_valid();
        check_result(16'h1234, 16'hFEDC);
        word_a = 16'h0ABC; word_b = 16'h0543;
        chk(busy == 1'b1, "R8 held request keeps busy", busy, 1);
        wait_valid();
        check_result(16'h0ABC, 16'h0543);
        repeat (300) @(negedge clk);
        chk(frames - f0 == 2, "R8 exactly one held frame", frames - f0, 2);
        chk(busy == 1'b0, "R8 idle after held frame", busy, 0);

        // R9 / R10: noise on deselected lines
        keep_a = res_a; keep_b = res_b;
        saw_valid = 1'b0;
        for (int n = 0; n < 40; n++) begin
            @(negedge clk);
            noise_a = n[0] ^ n[2];
            noise_b = ~n[1];
            if (res_valid) saw_valid = 1'b1;
        end
        chk(res_a == keep_a, "R9 res_a unchanged", res_a, keep_a);
        chk(res_b == keep_b, "R9 res_b unchanged", res_b, keep_b);
        chk(saw_valid == 1'b0, "R9 no valid while idle", saw_valid, 0);
        chk(sclk == 1'b1 && cs_n == 1'b1, "R10 idle levels", {cs_n, sclk}, 3);
        run_frame(16'h5A5A, 16'hC3C3, 5);

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule